// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block gathers the level-sensitive interrupt pins of a set of PCI device slots and folds them onto four shared interrupt request lines (PIRQ0..PIRQ3). Each device presents four pin levels (INTA..INTD) and its slot number. The pin is rotated by the slot number so that devices in neighbouring slots spread their first pin across different shared lines. Any number of devices may land on the same shared line; the line is high while any of them is high.

Each shared line then passes through a programmable steering register that picks one of sixteen interrupt-controller inputs, or disconnects the line. The result is a 16-bit vector of registered request levels. A separate pair of byte registers, written over the I/O port space, holds one trigger-mode bit per interrupt number and is driven out as a vector for the interrupt controller to consume. Firmware normally programs the four steering registers to IRQ 11, 9, 11, 9 and marks those numbers level-triggered.

Top module: `swz_router`

## Requirements
- R1: After reset, `irqLevel` and `irqTrigLevel` are all zero and all four steering registers are disabled, so no device level reaches `irqLevel` until software programs a route.
- R2: Pin p of a device (0 = INTA, 3 = INTD) in slot s drives shared line (p + s) mod 4; only the two low bits of the slot number matter.
- R3: A shared line is the OR of every device pin assigned to it; with all device levels low, `irqLevel` is zero one clock later.
- R4: The steering register of shared line n is written by a configuration byte write to offset 0x60 + n; bits 3:0 of the byte select the IRQ number, bit 7 set disconnects the line, bits 6:4 have no effect.
- R5: When several connected shared lines steer to the same IRQ, that IRQ's level is the OR of those lines; at most four IRQ bits are high at once.
- R6: `irqLevel` reflects device levels and steering registers as sampled at the previous rising clock edge: a change of either appears exactly one clock later.
- R7: An I/O byte write to 0x4D0 loads `irqTrigLevel[7:0]` and one to 0x4D1 loads `irqTrigLevel[15:8]` at the write edge; bit (irq & 7) of byte (irq >> 3) set means IRQ irq is level-triggered.
- R8: Configuration writes to offsets outside 0x60..0x63 and I/O writes to addresses other than 0x4D0/0x4D1 change neither the steering nor `irqTrigLevel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devLevel | input | NUM_DEV*4 | Pin levels, bit 4*d+p is pin p of device d |
| devSlot | input | NUM_DEV*SLOT_W | Slot number of each device, field d at bits d*SLOT_W upward |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write byte |
| ioWrEn | input | 1 | I/O byte write strobe |
| ioAddr | input | 16 | I/O port address |
| ioWrData | input | 8 | I/O write byte |
| irqLevel | output | 16 | Registered interrupt request level per IRQ number |
| irqTrigLevel | output | 16 | Trigger mode per IRQ number, 1 = level |

## Verification
A wrong rotation or a stale steering register shows up at `irqLevel` one clock after the offending pin rises: the request lands on the wrong IRQ bit, or on none. A corrupted trigger-mode byte is visible on `irqTrigLevel` on the very edge after the write, and a decode that answers the wrong offset alters an output the next cycle even though the bench drove no legal write. Sweeps over every slot, pin and steering value of a small device count expose each such fault within two cycles of the stimulus.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int NUM_PIRQ   = 4;
  localparam int NUM_IRQ    = 16;
  localparam int IRQ_W      = $clog2(NUM_IRQ);
  localparam int TRIG_BYTES = NUM_IRQ / 8;

  // Write strobes from the decoder to the datapath
  typedef struct packed {
    logic [NUM_PIRQ-1:0]   routeWr;
    logic [TRIG_BYTES-1:0] trigWr;
    logic [7:0]            cfgData;
    logic [7:0]            ioData;
  } wrStrobe_t;
endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
#(
  parameter logic [7:0]  ROUTE_BASE = 8'h60,
  parameter logic [15:0] TRIG_BASE  = 16'h04D0
) (
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgAddr,
  input  logic [7:0]  cfgWrData,
  input  logic        ioWrEn,
  input  logic [15:0] ioAddr,
  input  logic [7:0]  ioWrData,
  output wrStrobe_t   strobe
);
  always_comb begin
    strobe = '0;
    for (int n = 0; n < NUM_PIRQ; n++) begin
      strobe.routeWr[n] = cfgWrEn && (cfgAddr == ROUTE_BASE + 8'(n));
    end
    for (int b = 0; b < TRIG_BYTES; b++) begin
      strobe.trigWr[b] = ioWrEn && (ioAddr == TRIG_BASE + 16'(b));
    end
    strobe.cfgData = cfgWrData;
    strobe.ioData  = ioWrData;
  end
endmodule

// File: rtl/swz_datapath.sv
module swz_datapath
  import swz_pkg::*;
#(
  parameter int NUM_DEV = 64,
  parameter int SLOT_W  = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_DEV*4-1:0]      devLevel,
  input  logic [NUM_DEV*SLOT_W-1:0] devSlot,
  input  wrStrobe_t                 strobe,
  output logic [NUM_IRQ-1:0]        irqLevel,
  output logic [NUM_IRQ-1:0]        irqTrigLevel
);
  logic [NUM_PIRQ-1:0] routeOff;
  logic [IRQ_W-1:0]    routeIrq [NUM_PIRQ];
  logic [NUM_PIRQ-1:0] devPirq [NUM_DEV];
  logic [NUM_PIRQ-1:0] pirqLvl;
  logic [NUM_IRQ-1:0]  irqNext;
  logic                unusedBits;

  assign unusedBits = ^{devSlot, strobe.cfgData[6:4]};

  // Steering registers: disable flag plus IRQ number
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeOff <= '1;
      for (int n = 0; n < NUM_PIRQ; n++) routeIrq[n] <= '0;
    end else begin
      for (int n = 0; n < NUM_PIRQ; n++) begin
        if (strobe.routeWr[n]) begin
          routeOff[n] <= strobe.cfgData[7];
          routeIrq[n] <= strobe.cfgData[IRQ_W-1:0];
        end
      end
    end
  end

  // Trigger-mode byte registers
  genvar b;
  generate
    for (b = 0; b < TRIG_BYTES; b++) begin : gTrig
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) irqTrigLevel[b*8 +: 8] <= '0;
        else if (strobe.trigWr[b]) irqTrigLevel[b*8 +: 8] <= strobe.ioData;
      end
    end
  endgenerate

  // Per-device rotation of the pins by the slot number
  genvar d;
  generate
    for (d = 0; d < NUM_DEV; d++) begin : gDev
      logic [1:0] slotLo;
      logic [7:0] dbl;
      assign slotLo = devSlot[d*SLOT_W +: 2];
      assign dbl = {devLevel[d*4 +: 4], devLevel[d*4 +: 4]} << slotLo;
      assign devPirq[d] = dbl[7:4];
    end
  endgenerate

  // Wire-OR of all devices onto the shared lines, then steering
  always_comb begin
    pirqLvl = '0;
    for (int i = 0; i < NUM_DEV; i++) pirqLvl |= devPirq[i];
    irqNext = '0;
    for (int n = 0; n < NUM_PIRQ; n++) begin
      if (!routeOff[n] && pirqLvl[n]) irqNext[routeIrq[n]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqLevel <= '0;
    else       irqLevel <= irqNext;
  end
endmodule

// File: rtl/swz_router.sv
module swz_router
  import swz_pkg::*;
#(
  parameter int          NUM_DEV    = 64,
  parameter int          SLOT_W     = 5,
  parameter logic [7:0]  ROUTE_BASE = 8'h60,
  parameter logic [15:0] TRIG_BASE  = 16'h04D0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_DEV*4-1:0]      devLevel,
  input  logic [NUM_DEV*SLOT_W-1:0] devSlot,
  input  logic                      cfgWrEn,
  input  logic [7:0]                cfgAddr,
  input  logic [7:0]                cfgWrData,
  input  logic                      ioWrEn,
  input  logic [15:0]               ioAddr,
  input  logic [7:0]                ioWrData,
  output logic [15:0]               irqLevel,
  output logic [15:0]               irqTrigLevel
);
  wrStrobe_t strobe;

  swz_ctrl #(.ROUTE_BASE(ROUTE_BASE), .TRIG_BASE(TRIG_BASE)) uCtrl (
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .strobe(strobe)
  );

  swz_datapath #(.NUM_DEV(NUM_DEV), .SLOT_W(SLOT_W)) uData (
    .clk(clk), .rstN(rstN), .devLevel(devLevel), .devSlot(devSlot),
    .strobe(strobe), .irqLevel(irqLevel), .irqTrigLevel(irqTrigLevel)
  );
endmodule

// File: rtl/swz_checker.sv
module swz_checker #(
  parameter int          NUM_DEV   = 64,
  parameter logic [15:0] TRIG_BASE = 16'h04D0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_DEV*4-1:0] devLevel,
  input logic                 ioWrEn,
  input logic [15:0]          ioAddr,
  input logic [7:0]           ioWrData,
  input logic [15:0]          irqLevel,
  input logic [15:0]          irqTrigLevel
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqLevel == '0 && irqTrigLevel == '0));

  assert_no_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    (devLevel == '0) |=> (irqLevel == '0));

  assert_max_four_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqLevel) <= 4);

  assert_needs_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> $past(devLevel != '0));

  assert_trig_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr == TRIG_BASE) |=> (irqTrigLevel[7:0] == $past(ioWrData)));

  assert_trig_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && ioAddr == TRIG_BASE + 16'd1) |=> (irqTrigLevel[15:8] == $past(ioWrData)));

  assert_trig_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ioWrEn |=> $stable(irqTrigLevel));
endmodule

bind swz_router swz_checker #(.NUM_DEV(NUM_DEV), .TRIG_BASE(TRIG_BASE)) uChk (
  .clk(clk), .rstN(rstN), .devLevel(devLevel), .ioWrEn(ioWrEn),
  .ioAddr(ioAddr), .ioWrData(ioWrData), .irqLevel(irqLevel),
  .irqTrigLevel(irqTrigLevel)
);

// File: tb/tb_swz_router.sv
`timescale 1ns/1ps
module tb_swz_router;
  localparam int NDEV = 8;
  localparam int SW   = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NDEV*4-1:0] devLevel = '0;
  logic [NDEV*SW-1:0] devSlot = '0;
  logic              cfgWrEn = 1'b0;
  logic [7:0]        cfgAddr = '0;
  logic [7:0]        cfgWrData = '0;
  logic              ioWrEn = 1'b0;
  logic [15:0]       ioAddr = '0;
  logic [7:0]        ioWrData = '0;
  logic [15:0]       irqLevel;
  logic [15:0]       irqTrigLevel;

  swz_router #(.NUM_DEV(NDEV), .SLOT_W(SW)) dut (
    .clk(clk), .rstN(rstN), .devLevel(devLevel), .devSlot(devSlot),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .ioWrEn(ioWrEn), .ioAddr(ioAddr), .ioWrData(ioWrData),
    .irqLevel(irqLevel), .irqTrigLevel(irqTrigLevel)
  );

  always #2 clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;
  logic [7:0]  rt [4];
  logic [15:0] trigExp;
  logic [31:0] lfsr = 32'hACE1_2468;

  // Expected IRQ vector from the requirements
  function automatic logic [15:0] model();
    logic [3:0]  pq = '0;
    logic [15:0] e = '0;
    for (int d = 0; d < NDEV; d++)
      for (int p = 0; p < 4; p++)
        if (devLevel[d*4+p]) pq[(p + int'(devSlot[d*SW +: SW])) % 4] = 1'b1;
    for (int n = 0; n < 4; n++)
      if (!rt[n][7] && pq[n]) e[int'(rt[n][3:0])] = 1'b1;
    return e;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the write edge
  task automatic cfgWrite(input logic [7:0] a, input logic [7:0] v);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (a >= 8'h60 && a <= 8'h63) rt[int'(a - 8'h60)] = v;
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] v);
    ioWrEn = 1'b1; ioAddr = a; ioWrData = v;
    @(negedge clk);
    ioWrEn = 1'b0;
    if (a == 16'h04D0) trigExp[7:0] = v;
    if (a == 16'h04D1) trigExp[15:8] = v;
  endtask

  task automatic nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = lfsr ^ (lfsr << 13) ^ (lfsr >> 7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 4; n++) rt[n] = 8'h80;
    trigExp = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 irqLevel after reset", irqLevel, 16'h0000);
    check("R1 irqTrigLevel after reset", irqTrigLevel, 16'h0000);
    devLevel = '1;
    @(negedge clk);
    check("R1 routes disabled after reset", irqLevel, 16'h0000);
    devLevel = '0;

    // Typical firmware steering 11, 9, 11, 9
    cfgWrite(8'h60, 8'd11); cfgWrite(8'h61, 8'd9);
    cfgWrite(8'h62, 8'd11); cfgWrite(8'h63, 8'd9);
    for (int n = 0; n < 4; n++) begin
      devLevel = '0; devLevel[n] = 1'b1;
      @(negedge clk);
      check("R5 default steering single line", irqLevel, (n % 2 == 0) ? 16'h0800 : 16'h0200);
    end
    devLevel = '0; devLevel[0] = 1'b1; devLevel[2] = 1'b1;
    @(negedge clk);
    check("R5 two lines on IRQ 11", irqLevel, 16'h0800);
    devLevel[2] = 1'b0;
    @(negedge clk);
    check("R5 one of two lines dropped", irqLevel, 16'h0800);

    // R2: sweep device, slot and pin with distinct targets
    cfgWrite(8'h60, 8'd3); cfgWrite(8'h61, 8'd5);
    cfgWrite(8'h62, 8'd10); cfgWrite(8'h63, 8'd14);
    for (int d = 0; d < NDEV; d++)
      for (int s = 0; s < 8; s++)
        for (int p = 0; p < 4; p++) begin
          devLevel = '0;
          devSlot = '0;
          devSlot[d*SW +: SW] = 5'(s + 8 * (d % 4));
          devLevel[d*4+p] = 1'b1;
          @(negedge clk);
          check("R2 pin rotation by slot", irqLevel, model());
          check("R2 arithmetic target", irqLevel,
                16'(1) << int'(rt[(p + s) % 4][3:0]));
        end

    // R4: every IRQ number, disable bit and junk in bits 6:4
    devSlot = '0;
    for (int n = 0; n < 4; n++)
      for (int q = 0; q < 16; q++)
        for (int b7 = 0; b7 < 2; b7++) begin
          devLevel = '0; devLevel[n] = 1'b1;
          cfgWrite(8'h60 + 8'(n), {1'(b7), 3'(q * 5 + n), 4'(q)});
          @(negedge clk);
          check("R4 steering register fields", irqLevel,
                (b7 == 1) ? 16'h0000 : (16'(1) << q));
        end

    // R3/R5: pseudo-random sparse levels, slots and steering
    for (int it = 0; it < 400; it++) begin
      if (it % 8 == 0) begin
        nextRand();
        cfgWrite(8'h60 + 8'(lfsr[1:0]), lfsr[15:8] & 8'h8F | {1'b0, lfsr[22:20], 4'b0});
      end
      nextRand();
      devLevel = lfsr[NDEV*4-1:0];
      nextRand();
      devLevel = devLevel & lfsr[NDEV*4-1:0];
      nextRand();
      devSlot = {lfsr[7:0], lfsr};
      @(negedge clk);
      check("R3 wire-OR random pattern", irqLevel, model());
    end

    // R6: one clock of latency for levels and steering
    devLevel = '0; devSlot = '0;
    cfgWrite(8'h60, 8'd1); cfgWrite(8'h61, 8'd2);
    cfgWrite(8'h62, 8'd4); cfgWrite(8'h63, 8'd8);
    @(negedge clk);
    check("R3 all levels low", irqLevel, 16'h0000);
    devLevel[0] = 1'b1;
    #1;
    check("R6 before edge", irqLevel, 16'h0000);
    @(negedge clk);
    check("R6 one clock after level", irqLevel, 16'h0002);
    cfgWrite(8'h60, 8'd7);
    check("R6 old route at write edge", irqLevel, 16'h0002);
    @(negedge clk);
    check("R6 new route one clock later", irqLevel, 16'h0080);
    devLevel = '0;
    @(negedge clk);
    check("R3 level release", irqLevel, 16'h0000);

    // R7: trigger-mode bytes
    ioWrite(16'h04D0, 8'h5A);
    check("R7 low byte", irqTrigLevel, trigExp);
    ioWrite(16'h04D1, 8'hC3);
    check("R7 high byte", irqTrigLevel, trigExp);
    for (int q = 0; q < 16; q++) begin
      ioWrite(16'h04D0 + 16'(q / 8), 8'(1 << (q % 8)));
      check("R7 single IRQ level bit", irqTrigLevel, trigExp);
    end
    ioWrite(16'h04D0, 8'h00); ioWrite(16'h04D1, 8'h00);
    ioWrite(16'h04D0, 8'h00); ioWrite(16'h04D1, 8'h0A);
    check("R7 firmware IRQ 9 and 11", irqTrigLevel, 16'h0A00);

    // R8: stray writes
    devLevel = '0; devLevel[1] = 1'b1; devLevel[4] = 1'b1;
    devSlot[SW +: SW] = 5'd0;
    cfgWrite(8'h5F, 8'h0C);
    cfgWrite(8'h64, 8'h0D);
    cfgWrite(8'hE0, 8'h0E);
    cfgWrite(8'h00, 8'h0F);
    @(negedge clk);
    check("R8 stray config writes", irqLevel, model());
    check("R8 stray config arithmetic", irqLevel, 16'h0084);
    ioWrite(16'h04D2, 8'hFF);
    ioWrite(16'h04CF, 8'hFF);
    ioWrite(16'h14D0, 8'hFF);
    check("R8 stray I/O writes", irqTrigLevel, 16'h0A00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule